// File: doc/BRIEF.md
# Keystroke to Letter Event Encoder

This block sits between a keyboard front end and a processor register. The front end hands it one assembled 8-bit key code at a time, marked by a one-cycle strobe. The block looks the code up and keeps only the letters A to Z. For each letter it forms a 32-bit word with the letter's index in the low bits and a flag in the top bit. It also raises a write enable and holds it for several clock cycles, so that the register capturing the word cannot miss the event.

Two code sets are supported. One is the keyboard make-code set: a 256-entry table, computed at elaboration, turns each code into a character. The other is a character mode, where the incoming byte already is the character. In the make-code set, a release prefix byte causes the byte that follows it to be discarded, so letting go of a key does not produce a second letter.

Top module: `letter_event_enc`

## Requirements
- R1: While `rst` is high at a rising edge, `letter_word` becomes 0 and `letter_we` becomes 0 after that edge. The release-prefix state is cleared as well.
- R2: With `CODE_SET` = make-code set, the strobed codes produce these indices: A=0x1C→0, B=0x32→1, C=0x21→2, D=0x23→3, E=0x24→4, F=0x2B→5, G=0x34→6, H=0x33→7, I=0x43→8, J=0x3B→9, K=0x42→10, L=0x4B→11, M=0x3A→12, N=0x31→13, O=0x44→14, P=0x4D→15, Q=0x15→16, R=0x2D→17, S=0x1B→18, T=0x2C→19, U=0x3C→20, V=0x2A→21, W=0x1D→22, X=0x22→23, Y=0x35→24, Z=0x1A→25.
- R3: With `CODE_SET` = character mode, byte values 65..90 produce index value−65, and byte values 97..122 produce index value−97.
- R4: An accepted letter sets `letter_word` to bit 31 = 1 and bits 4:0 = index, with every other bit 0.
- R5: `letter_we` rises in the cycle after the edge that samples an accepted letter. It stays high for exactly `PULSE_CYCLES` cycles if no further letter arrives.
- R6: A strobed code that is not a letter leaves `letter_word` unchanged. It also leaves the running enable count unchanged.
- R7: In the make-code set, a strobed byte 0xF0 arms a release state, and the next strobed byte is discarded whatever its value. 0xF0 itself never produces a letter.
- R8: A letter accepted while `letter_we` is high replaces `letter_word` and restarts the enable count at `PULSE_CYCLES`.
- R9: `letter_word` changes only after an edge that samples an accepted letter or reset. It holds steady for the whole enable window and afterwards.
- R10: While `key_valid` is low, `key_code` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| key_code | input | 8 | Assembled key code or character from the front end |
| key_valid | input | 1 | One-cycle strobe marking `key_code` as a new key event |
| letter_word | output | 32 | Flag in bit 31, letter index in bits 4:0 |
| letter_we | output | 1 | Stretched write enable for the processor register |

## Verification
The bench builds two copies of the block and drives both from one input stream. The first uses the make-code set with a four-cycle window, which exercises the full computed lookup table and the release-prefix swallowing. The second uses character mode with a two-cycle window, so it covers upper and lower case folding. Because its window is short, it also sees a window end and a new window begin in close succession. In both copies, letters that arrive inside an open window exercise the restart rule. Make-code bytes that happen to be letters in character mode, and the reverse, check that each lookup variant rejects the other's codes.

// File: rtl/klev_pkg.sv
`timescale 1ns/1ps
package klev_pkg;

    localparam int KEY_W      = 8;
    localparam int LETTERS    = 26;
    localparam int IDX_W      = $clog2(LETTERS);
    localparam int TBL_DEPTH  = 1 << KEY_W;

    localparam logic [KEY_W-1:0] REL_PREFIX = 8'hF0;
    localparam logic [7:0]       UPPER_BASE = 8'd65;
    localparam logic [7:0]       LOWER_BASE = 8'd97;

    typedef enum logic [0:0] {
        SET_CHAR  = 1'b0,
        SET_MAKE  = 1'b1
    } code_set_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } letter_evt_t;

    // Make code to upper-case character; 0 for anything that is not a letter.
    function automatic logic [7:0] make_to_char(input logic [KEY_W-1:0] mc);
        logic [7:0] ch;
        case (mc)
            8'h1C: ch = "A";
            8'h32: ch = "B";
            8'h21: ch = "C";
            8'h23: ch = "D";
            8'h24: ch = "E";
            8'h2B: ch = "F";
            8'h34: ch = "G";
            8'h33: ch = "H";
            8'h43: ch = "I";
            8'h3B: ch = "J";
            8'h42: ch = "K";
            8'h4B: ch = "L";
            8'h3A: ch = "M";
            8'h31: ch = "N";
            8'h44: ch = "O";
            8'h4D: ch = "P";
            8'h15: ch = "Q";
            8'h2D: ch = "R";
            8'h1B: ch = "S";
            8'h2C: ch = "T";
            8'h3C: ch = "U";
            8'h2A: ch = "V";
            8'h1D: ch = "W";
            8'h22: ch = "X";
            8'h35: ch = "Y";
            8'h1A: ch = "Z";
            default: ch = 8'h00;
        endcase
        return ch;
    endfunction

    // Character to letter event, folding lower case onto upper case.
    function automatic letter_evt_t char_to_evt(input logic [7:0] ch);
        letter_evt_t e;
        logic [7:0]  off;
        e   = '0;
        off = '0;
        if (ch >= UPPER_BASE && ch < UPPER_BASE + 8'(LETTERS)) begin
            off   = ch - UPPER_BASE;
            e.hit = 1'b1;
        end else if (ch >= LOWER_BASE && ch < LOWER_BASE + 8'(LETTERS)) begin
            off   = ch - LOWER_BASE;
            e.hit = 1'b1;
        end
        e.idx = off[IDX_W-1:0];
        return e;
    endfunction

endpackage

// File: rtl/klev_keymap.sv
`timescale 1ns/1ps
module klev_keymap
    import klev_pkg::*;
#(
    parameter code_set_e CODE_SET = SET_MAKE
)(
    input  logic [KEY_W-1:0] code,
    output letter_evt_t      evt
);

    generate
        if (CODE_SET == SET_MAKE) begin : g_make
            logic [7:0] char_tbl [TBL_DEPTH];
            for (genvar i = 0; i < TBL_DEPTH; i++) begin : g_ent
                assign char_tbl[i] = make_to_char(KEY_W'(i));
            end
            assign evt = char_to_evt(char_tbl[code]);
        end else begin : g_char
            assign evt = char_to_evt(code);
        end
    endgenerate

endmodule

// File: rtl/klev_release_filter.sv
`timescale 1ns/1ps
module klev_release_filter
    import klev_pkg::*;
#(
    parameter bit USE_PREFIX = 1'b1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] code,
    input  logic             valid,
    output logic             pass
);

    logic armed_q;
    logic is_prefix;

    assign is_prefix = USE_PREFIX && (code == REL_PREFIX);
    assign pass      = valid && !armed_q && !is_prefix;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (valid) begin
            armed_q <= !armed_q && is_prefix;
        end
    end

endmodule

// File: rtl/klev_stretch.sv
`timescale 1ns/1ps
module klev_stretch #(
    parameter int CYCLES = 4
)(
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic active
);

    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/letter_event_enc.sv
`timescale 1ns/1ps
module letter_event_enc
    import klev_pkg::*;
#(
    parameter code_set_e CODE_SET     = SET_MAKE,
    parameter int        PULSE_CYCLES = 4,
    parameter int        WORD_W       = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [KEY_W-1:0]  key_code,
    input  logic              key_valid,
    output logic [WORD_W-1:0] letter_word,
    output logic              letter_we
);

    localparam int FLAG_BIT = WORD_W - 1;

    logic              strobe_ok;
    letter_evt_t       evt;
    logic              accept;
    logic [WORD_W-1:0] word_n;
    logic [WORD_W-1:0] word_q;

    klev_release_filter #(
        .USE_PREFIX (CODE_SET == SET_MAKE)
    ) u_rel (
        .clk   (clk),
        .rst   (rst),
        .code  (key_code),
        .valid (key_valid),
        .pass  (strobe_ok)
    );

    klev_keymap #(
        .CODE_SET (CODE_SET)
    ) u_map (
        .code (key_code),
        .evt  (evt)
    );

    assign accept = strobe_ok && evt.hit;

    always_comb begin
        word_n              = '0;
        word_n[FLAG_BIT]    = 1'b1;
        word_n[IDX_W-1:0]   = evt.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (accept) begin
            word_q <= word_n;
        end
    end

    klev_stretch #(
        .CYCLES (PULSE_CYCLES)
    ) u_str (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .active (letter_we)
    );

    assign letter_word = word_q;

endmodule

// File: rtl/klev_checker.sv
`timescale 1ns/1ps
module klev_checker
    import klev_pkg::*;
#(
    parameter int PULSE_CYCLES = 4,
    parameter int WORD_W       = 32
)(
    input logic              clk,
    input logic              rst,
    input logic              key_valid,
    input logic [WORD_W-1:0] letter_word,
    input logic              letter_we
);

    localparam int RUN_W = $clog2(PULSE_CYCLES + 2) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || key_valid || !letter_we) begin
            run_q <= '0;
        end else if (run_q != {RUN_W{1'b1}}) begin
            run_q <= run_q + 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (letter_word == '0 && !letter_we)); // R1

    AST_WE_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        letter_we |-> letter_word[WORD_W-1]); // R4

    AST_WORD_FIELDS: assert property (@(posedge clk) disable iff (rst)
        letter_word[WORD_W-1] |-> (letter_word[WORD_W-2:IDX_W] == '0
                                   && letter_word[IDX_W-1:0] < IDX_W'(LETTERS))); // R4

    AST_WE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(letter_we) |-> $past(key_valid)); // R5

    AST_WE_MAX_LEN: assert property (@(posedge clk) disable iff (rst)
        letter_we |-> (run_q < RUN_W'(PULSE_CYCLES))); // R5

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !key_valid |=> $stable(letter_word)); // R9

endmodule

bind letter_event_enc klev_checker #(
    .PULSE_CYCLES (PULSE_CYCLES),
    .WORD_W       (WORD_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .key_valid   (key_valid),
    .letter_word (letter_word),
    .letter_we   (letter_we)
);

// File: tb/sim_letter_event_enc.sv
`timescale 1ns/1ps
module sim_letter_event_enc;
    import klev_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int P0 = 4;
    localparam int P1 = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  kc  = 8'h00;
    logic        kv  = 1'b0;
    logic [31:0] w0, w1;
    logic        we0, we1;

    int checks   = 0;
    int failures = 0;

    logic [31:0] m0_word = 32'h0, m1_word = 32'h0;
    int          m0_cnt = 0, m1_cnt = 0;
    logic        m0_arm = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    letter_event_enc #(.CODE_SET(SET_MAKE), .PULSE_CYCLES(P0), .WORD_W(32)) u0 (
        .clk(clk), .rst(rst), .key_code(kc), .key_valid(kv),
        .letter_word(w0), .letter_we(we0));

    letter_event_enc #(.CODE_SET(SET_CHAR), .PULSE_CYCLES(P1), .WORD_W(32)) u1 (
        .clk(clk), .rst(rst), .key_code(kc), .key_valid(kv),
        .letter_word(w1), .letter_we(we1));

    function automatic logic [7:0] make_code(input int i);
        case (i)
            0: return 8'h1C;  1: return 8'h32;  2: return 8'h21;  3: return 8'h23;
            4: return 8'h24;  5: return 8'h2B;  6: return 8'h34;  7: return 8'h33;
            8: return 8'h43;  9: return 8'h3B; 10: return 8'h42; 11: return 8'h4B;
           12: return 8'h3A; 13: return 8'h31; 14: return 8'h44; 15: return 8'h4D;
           16: return 8'h15; 17: return 8'h2D; 18: return 8'h1B; 19: return 8'h2C;
           20: return 8'h3C; 21: return 8'h2A; 22: return 8'h1D; 23: return 8'h22;
           24: return 8'h35; default: return 8'h1A;
        endcase
    endfunction

    function automatic int make_idx(input logic [7:0] c);
        for (int i = 0; i < 26; i++) if (make_code(i) == c) return i;
        return -1;
    endfunction

    function automatic int char_idx(input logic [7:0] c);
        if (c >= 8'd65 && c <= 8'd90)  return int'(c) - 65;
        if (c >= 8'd97 && c <= 8'd122) return int'(c) - 97;
        return -1;
    endfunction

    function automatic logic [31:0] expect_word(input int i);
        return 32'h8000_0000 | 32'(i);
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] c, input logic r, input string tag);
        int  i0, i1;
        logic pass0;
        @(negedge clk);
        kv = v; kc = c; rst = r;
        @(posedge clk);
        if (r) begin
            m0_word = 0; m0_cnt = 0; m0_arm = 0;
            m1_word = 0; m1_cnt = 0;
        end else begin
            pass0 = v && !m0_arm && (c != 8'hF0);
            if (v) m0_arm = !m0_arm && (c == 8'hF0);
            i0 = pass0 ? make_idx(c) : -1;
            if (i0 >= 0) begin m0_word = expect_word(i0); m0_cnt = P0; end
            else if (m0_cnt > 0) m0_cnt--;
            i1 = v ? char_idx(c) : -1;
            if (i1 >= 0) begin m1_word = expect_word(i1); m1_cnt = P1; end
            else if (m1_cnt > 0) m1_cnt--;
        end
        #(CLK_PERIOD/4);
        check(w0, m0_word, {tag, " u0 word"});
        check(32'(we0), 32'(m0_cnt != 0), {tag, " u0 we"});
        check(w1, m1_word, {tag, " u1 word"});
        check(32'(we1), 32'(m1_cnt != 0), {tag, " u1 we"});
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, 8'h00, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL R5 watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        step(1'b0, 8'h00, 1'b1, "R1 reset");
        step(1'b1, 8'h1C, 1'b1, "R1 reset with strobe");
        // R2 / R4 / R5: every make code, full window, then release pair (R7)
        for (int i = 0; i < 26; i++) begin
            step(1'b1, make_code(i), 1'b0, "R2 R4 letter");
            idle(P0, "R5 window");
            step(1'b1, 8'hF0, 1'b0, "R7 prefix");
            step(1'b1, make_code(i), 1'b0, "R7 swallowed");
            idle(1, "R7 after");
        end
        // R3: character mode upper and lower case
        for (int i = 0; i < 26; i++) begin
            step(1'b1, 8'(65 + i), 1'b0, "R3 upper");
            idle(P1, "R3 gap");
            step(1'b1, 8'(97 + i), 1'b0, "R3 lower");
            idle(P1 + 1, "R3 gap");
        end
        // R8: restart inside the window
        step(1'b1, make_code(0), 1'b0, "R8 first");
        idle(2, "R8 mid");
        step(1'b1, make_code(25), 1'b0, "R8 restart");
        idle(P0 + 1, "R8 tail");
        // R6: non-letters inside and outside the window
        step(1'b1, make_code(7), 1'b0, "R6 letter");
        step(1'b1, 8'h05, 1'b0, "R6 nonletter in window");
        step(1'b1, 8'h5B, 1'b0, "R6 nonletter in window");
        idle(P0, "R6 tail");
        step(1'b1, 8'h00, 1'b0, "R6 nonletter idle");
        step(1'b1, 8'hFF, 1'b0, "R6 nonletter idle");
        // R7: double prefix swallows the second, then a letter passes
        step(1'b1, 8'hF0, 1'b0, "R7 prefix");
        step(1'b1, 8'hF0, 1'b0, "R7 prefix swallowed");
        step(1'b1, make_code(3), 1'b0, "R7 letter after pair");
        idle(P0, "R7 tail");
        // R10: letter codes with strobe low
        for (int i = 0; i < 6; i++) step(1'b0, make_code(i), 1'b0, "R10 no strobe");
        for (int i = 0; i < 4; i++) step(1'b0, 8'(65 + i), 1'b0, "R10 no strobe");
        // R9 and mixed coverage: constrained random
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [7:0] c;
            logic v, r;
            sel = int'($urandom % 4);
            case (sel)
                0: c = 8'($urandom);
                1: c = make_code(int'($urandom % 26));
                2: c = 8'(($urandom % 2 == 0 ? 65 : 97) + ($urandom % 26));
                default: c = 8'hF0;
            endcase
            v = ($urandom % 3) == 0;
            r = ($urandom % 250) == 0;
            step(v, c, r, "R9 random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule